// File: doc/BRIEF.md
# SD Write CRC Status Checker

After the host has sent a write data block to an SD card, the card answers on DAT0. It first sends a short CRC status token. It then holds the line low for as long as it is busy programming. This block watches DAT0 in the cycles marked by the SD clock enable strobe. It finds the token's start bit, collects the three token bits and checks the closing end bit. It then times the busy period that follows.

Each outcome leaves the block as a single-cycle pulse to the error status logic:

- a rejected token;
- a bad end bit;
- a timeout, either while waiting for the token or while the card is busy;
- completion, when the card releases DAT0.

The write datapath pulses `start` once the data block and its CRC have left the host. It supplies two timeout limits, both counted in enabled SD clock cycles.

After any outcome the checker goes back to idle. It takes no further notice of DAT0 until the next `start`.

Top module: `wr_crcstat_chk`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all four outputs are 0. A reset in the middle of a response abandons it, so no pulse follows for that response.
- R2: With no `start` since reset or since the last outcome, DAT0 activity produces no output pulse.
- R3: DAT0 is sampled only in cycles with `sdclk_en` high. The start bit is the first 0 sampled after `start`, and values present while `sdclk_en` is low have no effect.
- R4: The three enabled samples after the start bit form the token, first sample as its MSB. When the token is 010 and the next sample (the end bit) is 1, the block enters busy. The first enabled sample of 1 in busy gives one `done` pulse and no error.
- R5: A token other than 010 gives one `crc_err` pulse in the cycle after the end-bit sample, and the block goes idle.
- R6: An end-bit sample of 0 gives one `end_err` pulse in the cycle after that sample, together with `crc_err` when the token is also wrong, and the block goes idle.
- R7: While waiting for the start bit, `timeout_err` pulses once the number of enabled samples of 1 reaches `tok_limit`. A limit of 0 acts as 1.
- R8: In busy, `timeout_err` pulses once the number of enabled samples of 0 reaches `busy_limit`. A limit of 0 acts as 1.
- R9: After any error pulse the block is idle, and later DAT0 activity produces nothing until the next `start`.
- R10: A `start` pulse during any phase restarts the search for the start bit. The abandoned response produces no pulse.
- R11: Every output pulse lasts exactly one clock cycle. `done` never coincides with any error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdclk_en | input | 1 | Strobe marking the cycles in which DAT0 is sampled |
| dat0 | input | 1 | Sampled DAT0 line level |
| start | input | 1 | Pulse: write block sent, begin watching for the token |
| tok_limit | input | LIM_W | Enabled cycles allowed before the start bit |
| busy_limit | input | LIM_W | Enabled cycles allowed for busy |
| crc_err | output | 1 | Pulse: token not equal to 010 |
| end_err | output | 1 | Pulse: end bit sampled as 0 |
| timeout_err | output | 1 | Pulse: token or busy wait exceeded its limit |
| done | output | 1 | Pulse: busy ended without error |

## Verification
The token path is driven with the accepted value 010 and with several rejected values, including 101, 011 and 111. Each is paired with a good or a bad end bit, so that a CRC fault, an end-bit fault and both faults together each give a distinct set of pulses. Gaps before the start bit and busy lengths are placed one sample below and exactly at each limit, including a limit of 0. This separates a correct count from an off-by-one count. Between enabled samples the bench drives the opposite DAT0 level, so any sampling outside the strobe shows up as a false start bit or an early busy release. Directed runs cover DAT0 activity with no start, a restart in mid-token and a reset during busy.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    localparam int TOK_W = 3;
    localparam logic [TOK_W-1:0] TOK_ACCEPT = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_TOKEN,
        ST_STOP,
        ST_BUSY
    } wcs_state_e;

    typedef struct packed {
        logic crc;
        logic endb;
        logic tmo;
        logic done;
    } wcs_evt_t;

    function automatic logic tok_bad(input logic [TOK_W-1:0] t);
        return t != TOK_ACCEPT;
    endfunction

endpackage

// File: rtl/wcs_timer.sv
module wcs_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         at_lim
);
    logic [W-1:0] cnt_q;
    logic [W:0]   next_w;

    assign next_w = {1'b0, cnt_q} + 1'b1;
    // the sample now being counted reaches the limit (0 behaves as 1)
    assign at_lim = next_w >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step && !at_lim) begin
            cnt_q <= next_w[W-1:0];
        end
    end
endmodule

// File: rtl/wcs_token.sv
module wcs_token
    import wcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [TOK_W-1:0] tok,
    output logic             last
);
    localparam int CW = $clog2(TOK_W + 1);

    logic [CW-1:0] n_q;

    assign last = shift && (n_q == CW'(TOK_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tok <= '0;
            n_q <= '0;
        end else if (shift) begin
            tok <= {tok[TOK_W-2:0], bit_in};
            n_q <= n_q + 1'b1;
        end
    end
endmodule

// File: rtl/wr_crcstat_chk.sv
module wr_crcstat_chk
    import wcs_pkg::*;
#(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdclk_en,
    input  logic             dat0,
    input  logic             start,
    input  logic [LIM_W-1:0] tok_limit,
    input  logic [LIM_W-1:0] busy_limit,
    output logic             crc_err,
    output logic             end_err,
    output logic             timeout_err,
    output logic             done
);
    wcs_state_e state_q, state_d;
    wcs_evt_t   evt_d, evt_q;

    logic             tmr_clr, tmr_step, tmr_hit;
    logic [LIM_W-1:0] tmr_lim;
    logic             tok_clr, tok_shift, tok_last;
    logic [TOK_W-1:0] tok_val;

    // one counter serves both waits; the phase selects its limit
    assign tmr_lim = (state_q == ST_BUSY) ? busy_limit : tok_limit;

    wcs_timer #(.W(LIM_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .step   (tmr_step),
        .limit  (tmr_lim),
        .at_lim (tmr_hit)
    );

    wcs_token u_token (
        .clk    (clk),
        .rst    (rst),
        .clr    (tok_clr),
        .shift  (tok_shift),
        .bit_in (dat0),
        .tok    (tok_val),
        .last   (tok_last)
    );

    always_comb begin
        state_d   = state_q;
        evt_d     = '0;
        tmr_clr   = 1'b0;
        tmr_step  = 1'b0;
        tok_clr   = 1'b0;
        tok_shift = 1'b0;
        if (start) begin
            state_d = ST_HUNT;
            tmr_clr = 1'b1;
            tok_clr = 1'b1;
        end else if (sdclk_en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (!dat0) begin
                        state_d = ST_TOKEN;
                    end else begin
                        tmr_step = 1'b1;
                        if (tmr_hit) begin
                            evt_d.tmo = 1'b1;
                            state_d   = ST_IDLE;
                        end
                    end
                end
                ST_TOKEN: begin
                    tok_shift = 1'b1;
                    if (tok_last) state_d = ST_STOP;
                end
                ST_STOP: begin
                    evt_d.crc  = tok_bad(tok_val);
                    evt_d.endb = !dat0;
                    if (tok_bad(tok_val) || !dat0) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_BUSY;
                        tmr_clr = 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (dat0) begin
                        evt_d.done = 1'b1;
                        state_d    = ST_IDLE;
                    end else begin
                        tmr_step = 1'b1;
                        if (tmr_hit) begin
                            evt_d.tmo = 1'b1;
                            state_d   = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
        end
    end

    assign crc_err     = evt_q.crc;
    assign end_err     = evt_q.endb;
    assign timeout_err = evt_q.tmo;
    assign done        = evt_q.done;
endmodule

// File: rtl/wcs_chk.sv
module wcs_chk
    import wcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sdclk_en,
    input logic       dat0,
    input logic       start,
    input wcs_state_e st,
    input logic       crc_err,
    input logic       end_err,
    input logic       timeout_err,
    input logic       done
);
    logic any_out;
    assign any_out = crc_err || end_err || timeout_err || done;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !any_out);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> !any_out);

    // R3
    gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sdclk_en |=> !any_out);

    // R4
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == ST_BUSY && $past(dat0)));

    // R5
    crc_src_chk: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> $past(st) == ST_STOP);

    // R6
    end_src_chk: assert property (@(posedge clk) disable iff (rst)
        end_err |-> ($past(st) == ST_STOP && !$past(dat0)));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (crc_err || end_err || timeout_err) |-> st == ST_IDLE);

    // R11
    done_width_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    tmo_width_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, timeout_err}) && !(done && (crc_err || end_err)));
endmodule

bind wr_crcstat_chk wcs_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .sdclk_en    (sdclk_en),
    .dat0        (dat0),
    .start       (start),
    .st          (state_q),
    .crc_err     (crc_err),
    .end_err     (end_err),
    .timeout_err (timeout_err),
    .done        (done)
);

// File: tb/test_wr_crcstat_chk.sv
module test_wr_crcstat_chk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdclk_en = 1'b0;
    logic        dat0 = 1'b1;
    logic        start = 1'b0;
    logic [15:0] tok_limit = 16'd8;
    logic [15:0] busy_limit = 16'd6;
    logic        crc_err, end_err, timeout_err, done;

    int n_tests = 0;
    int n_fail = 0;
    int n_crc = 0, n_end = 0, n_tmo = 0, n_done = 0;
    int b_crc, b_end, b_tmo, b_done;

    always #5 clk = ~clk;

    wr_crcstat_chk #(.LIM_W(16)) i_wr_crcstat_chk (
        .clk(clk), .rst(rst), .sdclk_en(sdclk_en), .dat0(dat0), .start(start),
        .tok_limit(tok_limit), .busy_limit(busy_limit),
        .crc_err(crc_err), .end_err(end_err), .timeout_err(timeout_err), .done(done)
    );

    // pulse counter: counts high cycles, so a stretched pulse shows up (R11)
    always @(negedge clk) begin
        if (crc_err)     n_crc++;
        if (end_err)     n_end++;
        if (timeout_err) n_tmo++;
        if (done)        n_done++;
    end

    // code = crc*1000 + end*100 + tmo*10 + done
    typedef struct packed {
        logic [7:0]  gap;
        logic [2:0]  tok;
        logic        endb;
        logic [7:0]  busy;
        logic [15:0] tl;
        logic [15:0] bl;
        logic [3:0]  exp;   // {crc, end, tmo, done}
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd2, 3'b010, 1'b1, 8'd3, 16'd8, 16'd6, 4'b0001},  // R4 good
        '{8'd0, 3'b010, 1'b1, 8'd0, 16'd8, 16'd6, 4'b0001},  // R4 no busy
        '{8'd2, 3'b101, 1'b1, 8'd3, 16'd8, 16'd6, 4'b1000},  // R5
        '{8'd1, 3'b011, 1'b1, 8'd2, 16'd8, 16'd6, 4'b1000},  // R5
        '{8'd2, 3'b010, 1'b0, 8'd2, 16'd8, 16'd6, 4'b0100},  // R6
        '{8'd1, 3'b111, 1'b0, 8'd2, 16'd8, 16'd6, 4'b1100},  // R5 R6
        '{8'd8, 3'b010, 1'b1, 8'd2, 16'd8, 16'd6, 4'b0010},  // R7 at limit
        '{8'd7, 3'b010, 1'b1, 8'd2, 16'd8, 16'd6, 4'b0001},  // R7 below
        '{8'd3, 3'b010, 1'b1, 8'd2, 16'd0, 16'd6, 4'b0010},  // R7 zero limit
        '{8'd0, 3'b010, 1'b1, 8'd2, 16'd0, 16'd6, 4'b0001},  // R7 zero limit
        '{8'd1, 3'b010, 1'b1, 8'd6, 16'd8, 16'd6, 4'b0010},  // R8 at limit
        '{8'd1, 3'b010, 1'b1, 8'd5, 16'd8, 16'd6, 4'b0001}   // R8 below
    };

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic snap();
        b_crc = n_crc; b_end = n_end; b_tmo = n_tmo; b_done = n_done;
    endtask

    function automatic int delta_code();
        return (n_crc - b_crc) * 1000 + (n_end - b_end) * 100
             + (n_tmo - b_tmo) * 10 + (n_done - b_done);
    endfunction

    task automatic tick(input logic en, input logic d);
        @(negedge clk);
        sdclk_en = en;
        dat0     = d;
    endtask

    // one enabled sample, then a gated cycle carrying the opposite level (R3)
    task automatic en_bit(input logic b);
        tick(1'b1, b);
        tick(1'b0, ~b);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1; sdclk_en = 1'b0; dat0 = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_frame(input int gap, input logic [2:0] tok, input logic endb,
                             input int busy, input logic [15:0] tl, input logic [15:0] bl);
        tok_limit  = tl;
        busy_limit = bl;
        pulse_start();
        repeat (gap) en_bit(1'b1);
        en_bit(1'b0);
        for (int k = 2; k >= 0; k--) en_bit(tok[k]);
        en_bit(endb);
        repeat (busy) en_bit(1'b0);
        en_bit(1'b1);
        repeat (3) en_bit(1'b1);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 outputs in reset", {28'd0, crc_err, end_err, timeout_err, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", {28'd0, crc_err, end_err, timeout_err, done}, 0);

        // R2: DAT0 toggling with no start
        snap();
        for (int i = 0; i < 10; i++) begin
            en_bit(1'b0);
            en_bit(1'b1);
        end
        check("R2 no start, pulse code", delta_code(), 0);

        // table walk: R4 R5 R6 R7 R8 R9 R11
        for (int i = 0; i < NV; i++) begin
            snap();
            run_frame(int'(VECS[i].gap), VECS[i].tok, VECS[i].endb,
                      int'(VECS[i].busy), VECS[i].tl, VECS[i].bl);
            check($sformatf("vector %0d (R4 R5 R6 R7 R8 R9 R11) pulse code", i),
                  delta_code(),
                  int'(VECS[i].exp[3]) * 1000 + int'(VECS[i].exp[2]) * 100
                + int'(VECS[i].exp[1]) * 10 + int'(VECS[i].exp[0]));
        end

        // R9: after a token error, a full good-looking sequence is ignored
        snap();
        run_frame(1, 3'b110, 1'b1, 1, 16'd8, 16'd6);
        en_bit(1'b0); en_bit(1'b0); en_bit(1'b1); en_bit(1'b0);
        en_bit(1'b1); en_bit(1'b0); en_bit(1'b1); en_bit(1'b1);
        check("R9 activity after error, pulse code", delta_code(), 1000);

        // R3: long gated stretch of zeros before the start bit, then a good frame
        snap();
        tok_limit = 16'd4; busy_limit = 16'd4;
        pulse_start();
        repeat (12) tick(1'b0, 1'b0);
        en_bit(1'b1);
        en_bit(1'b0);
        en_bit(1'b0); en_bit(1'b1); en_bit(1'b0);
        en_bit(1'b1);
        en_bit(1'b0);
        repeat (12) tick(1'b0, 1'b1);
        en_bit(1'b1);
        repeat (2) en_bit(1'b1);
        check("R3 gated cycles ignored, pulse code", delta_code(), 1);

        // R10: restart in the middle of the token
        snap();
        tok_limit = 16'd8; busy_limit = 16'd6;
        pulse_start();
        en_bit(1'b1);
        en_bit(1'b0);
        en_bit(1'b1);
        pulse_start();
        en_bit(1'b1);
        en_bit(1'b0);
        en_bit(1'b0); en_bit(1'b1); en_bit(1'b0);
        en_bit(1'b1);
        en_bit(1'b0);
        en_bit(1'b1);
        repeat (2) en_bit(1'b1);
        check("R10 restart mid-token, pulse code", delta_code(), 1);

        // R10: restart during busy abandons it without a pulse
        snap();
        pulse_start();
        en_bit(1'b0);
        en_bit(1'b0); en_bit(1'b1); en_bit(1'b0);
        en_bit(1'b1);
        en_bit(1'b0);
        pulse_start();
        repeat (5) en_bit(1'b1);
        check("R10 restart in busy, pulse code", delta_code(), 0);

        // R1: reset during busy abandons the response
        snap();
        pulse_start();
        en_bit(1'b0);
        en_bit(1'b0); en_bit(1'b1); en_bit(1'b0);
        en_bit(1'b1);
        en_bit(1'b0);
        en_bit(1'b0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) en_bit(1'b1);
        check("R1 reset mid-busy, pulse code", delta_code(), 0);

        // R11: a final good frame gives exactly one single-cycle done
        snap();
        run_frame(0, 3'b010, 1'b1, 1, 16'd8, 16'd6);
        check("R11 done pulse cycles", n_done - b_done, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule